// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is a serial peripheral interface master that runs one complete transfer for each accepted command. It makes the serial clock from the system clock with a modulus divider and supports every combination of clock polarity and clock phase. Each command selects one of two lead times between chip-select assertion and the first clock edge: half a serial clock period, or a programmed number of system clocks. Each command also selects the frame length: the default 8 bits, or a programmed length of 8 to 16 bits.

Configuration (divider, lead count, length code, polarity, phase) is read from static inputs when a command is accepted and held for the whole frame. The controller has four states:
- `ST_IDLE`: waits for a command. A command with a working divider moves to `ST_LEAD`. A command with a disabled divider stays in `ST_IDLE` and pulses done.
- `ST_LEAD`: counts the lead time, then makes the first clock edge and moves to `ST_SHIFT`.
- `ST_SHIFT`: makes one clock edge every divider period. After the final edge it moves to `ST_TAIL`.
- `ST_TAIL`: waits one half period, then releases chip select and returns to `ST_IDLE`.

Top module: `spi_xfer_engine`

## Requirements
- R1: During reset, sck, mosi, done and rx_data are 0 and cs_n is 1.
- R2: During a frame, consecutive sck edges are exactly cfg_div system clocks apart, so the serial clock frequency is the system clock frequency divided by 2×cfg_div (cfg_div from 2 to 255).
- R3: A command accepted while cfg_div is 0 or 1 raises done for one cycle in the following cycle. cs_n stays 1 and sck keeps its idle level.
- R4: While idle, sck equals the cfg_cpol value sampled one clock earlier. At the end of every frame, sck is back at the polarity the command was accepted with.
- R5: With phase 0, mosi shows the frame's MSB from the cycle in which cs_n falls. It changes only on trailing edges (edges 2, 4, …, excluding the last), and miso is sampled on leading edges (edges 1, 3, …).
- R6: With phase 1, mosi changes on leading edges from edge 3 onward, and miso is sampled on trailing edges.
- R7: With cmd_lead_sel = 0, the first sck edge comes cfg_div clocks after cs_n falls, and cfg_lead has no effect.
- R8: With cmd_lead_sel = 1, the first sck edge comes cfg_lead clocks after cs_n falls. A value of 0 is treated as 1.
- R9: With cmd_len_sel = 0, a frame has 8 bits whatever cfg_len holds. With cmd_len_sel = 1, code 0 gives 16 bits, codes 8 to 15 give that many bits, and codes 1 to 7 give 8 bits. A frame of N bits has 2N sck edges.
- R10: Bits are sent MSB first from the low N bits of tx_data. rx_data is cleared when a frame starts, and each sampled miso bit is shifted in at bit 0, so after a frame the received bits sit right-justified.
- R11: done is high for exactly one cycle, the cycle right after the last sampling edge.
- R12: cs_n returns to 1 cfg_div clocks after the final sck edge. mosi reads 0 whenever cs_n is 1.
- R13: cmd_valid and changes to the configuration inputs have no effect on a frame that is already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | 8 | Half-period divider value |
| cfg_lead | input | 7 | Programmed lead count in system clocks |
| cfg_len | input | 4 | Programmed frame length code |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock phase |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_lead_sel | input | 1 | 0: half-period lead, 1: programmed lead |
| cmd_len_sel | input | 1 | 0: 8-bit frame, 1: programmed length |
| tx_data | input | 16 | Transmit word; the low N bits are sent |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Peripheral select, active low |
| rx_data | output | 16 | Received bits, right-justified |
| done | output | 1 | One-cycle completion pulse |

## Verification
Frames are run across all four polarity/phase pairs, with divider values from 2 up to 255. These separate edge-placement errors that only show up in one phase or at one divider spacing. The two lead choices are paired with deliberately misleading values in the unused field: a large cfg_lead under the half-period lead, and a length code of 12 under the default length. This shows whether the ignored field leaks into the timing. Length codes 0, 5, 9, 12 and 15 cover the wrap, clamp and direct cases. Three further runs cover a disabled divider (0 and 1), a command plus configuration changes injected in the middle of a frame, and random miso data sampled on every edge; together they expose wrong sampling edges and commands accepted while busy.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } xfer_state_t;

endpackage

// File: rtl/spi_frame_len.sv
// Maps the per-command length select and the length code onto a bit count.
module spi_frame_len #(
    parameter int LEN_W    = 4,
    parameter int DEF_BITS = 8,
    localparam int DATA_W  = 1 << LEN_W,
    localparam int CNT_W   = LEN_W + 1
) (
    input  logic             len_sel,
    input  logic [LEN_W-1:0] len_code,
    output logic [CNT_W-1:0] nbits
);

    always_comb begin
        if (!len_sel) begin
            nbits = CNT_W'(DEF_BITS);
        end else if (len_code == '0) begin
            nbits = CNT_W'(DATA_W);
        end else if ({1'b0, len_code} < CNT_W'(DEF_BITS)) begin
            nbits = CNT_W'(DEF_BITS);
        end else begin
            nbits = {1'b0, len_code};
        end
    end

endmodule

// File: rtl/spi_edge_timer.sv
// Down counter that serves both the lead interval and every half period.
module spi_edge_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/spi_shift_pair.sv
// Transmit shifter (MSB at the top) and receive shifter (new bit at bit 0).
module spi_shift_pair #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              shift_out,
    input  logic              sample_in,
    input  logic              serial_in,
    output logic              serial_out,
    output logic [DATA_W-1:0] rx_word
);

    logic [DATA_W-1:0] tx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_word <= '0;
        end else if (load) begin
            tx_sh   <= load_word;
            rx_word <= '0;
        end else begin
            if (shift_out) begin
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
            if (sample_in) begin
                rx_word <= {rx_word[DATA_W-2:0], serial_in};
            end
        end
    end

    assign serial_out = tx_sh[DATA_W-1];

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int DLY_W    = 7,
    parameter int LEN_W    = 4,
    parameter int DEF_BITS = 8,
    localparam int DATA_W  = 1 << LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DLY_W-1:0]  cfg_lead,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cmd_valid,
    input  logic              cmd_lead_sel,
    input  logic              cmd_len_sel,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              cs_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              done
);

    localparam int CNT_W = LEN_W + 1;
    localparam int ECW   = CNT_W + 1;
    localparam int TW    = (DIV_W > DLY_W) ? DIV_W : DLY_W;

    xfer_state_t st, st_nxt;

    // Per-frame settings captured when a command is accepted
    logic [DIV_W-1:0] div_q;
    logic             cpol_q;
    logic             cpha_q;
    logic [CNT_W-1:0] nbits_q;

    logic [ECW-1:0]   edge_q;
    logic             sck_q;
    logic             cs_n_q;
    logic             done_q;

    logic [CNT_W-1:0]  nbits_cmd;
    logic [TW-1:0]     lead_len;
    logic [TW-1:0]     tmr_val;
    logic              tmr_expired;
    logic [DATA_W-1:0] tx_aligned;
    logic              sh_out;

    logic             div_off;
    logic             accept;
    logic             launch;
    logic             fire;
    logic             toggle;
    logic [ECW-1:0]   edge_num;
    logic [ECW-1:0]   edge_total;
    logic [ECW-1:0]   edge_last_take;
    logic             odd_edge;
    logic             rx_take;
    logic             tx_step;
    logic             final_edge;
    logic             last_take;

    spi_frame_len #(
        .LEN_W    (LEN_W),
        .DEF_BITS (DEF_BITS)
    ) u_len (
        .len_sel  (cmd_len_sel),
        .len_code (cfg_len),
        .nbits    (nbits_cmd)
    );

    // Lead time chosen per command; a zero programmed count behaves as one
    always_comb begin
        if (cmd_lead_sel) begin
            lead_len = (cfg_lead == '0) ? TW'(1) : TW'(cfg_lead);
        end else begin
            lead_len = TW'(cfg_div);
        end
    end

    assign div_off        = (cfg_div < DIV_W'(2));
    assign accept         = (st == ST_IDLE) && cmd_valid;
    assign launch         = accept && !div_off;
    assign fire           = tmr_expired && (st != ST_IDLE);
    assign toggle         = fire && ((st == ST_LEAD) || (st == ST_SHIFT));
    assign edge_num       = edge_q + 1'b1;
    assign edge_total     = {nbits_q, 1'b0};
    assign edge_last_take = cpha_q ? edge_total : (edge_total - 1'b1);
    assign odd_edge       = edge_num[0];
    assign rx_take        = toggle && (cpha_q ? !odd_edge : odd_edge);
    assign tx_step        = toggle && (cpha_q ? (odd_edge && (edge_num != ECW'(1)))
                                              : (!odd_edge && (edge_num != edge_total)));
    assign final_edge     = toggle && (edge_num == edge_total);
    assign last_take      = rx_take && (edge_num == edge_last_take);

    assign tmr_val    = launch ? (lead_len - TW'(1)) : (TW'(div_q) - TW'(1));
    assign tx_aligned = tx_data << (CNT_W'(DATA_W) - nbits_cmd);

    spi_edge_timer #(
        .W        (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch || toggle),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    spi_shift_pair #(
        .DATA_W     (DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (launch),
        .load_word  (tx_aligned),
        .shift_out  (tx_step),
        .sample_in  (rx_take),
        .serial_in  (miso),
        .serial_out (sh_out),
        .rx_word    (rx_data)
    );

    // Next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (launch)     st_nxt = ST_LEAD;
            ST_LEAD:  if (fire)       st_nxt = ST_SHIFT;
            ST_SHIFT: if (final_edge) st_nxt = ST_TAIL;
            ST_TAIL:  if (fire)       st_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Output and frame registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b0;
            edge_q  <= '0;
            div_q   <= '0;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            nbits_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    sck_q <= cfg_cpol;
                    if (accept) begin
                        if (div_off) begin
                            done_q <= 1'b1;
                        end else begin
                            cs_n_q  <= 1'b0;
                            div_q   <= cfg_div;
                            cpol_q  <= cfg_cpol;
                            cpha_q  <= cfg_cpha;
                            nbits_q <= nbits_cmd;
                            edge_q  <= '0;
                        end
                    end
                end
                ST_LEAD, ST_SHIFT: begin
                    if (toggle) begin
                        sck_q  <= ~sck_q;
                        edge_q <= edge_num;
                    end
                    if (last_take) begin
                        done_q <= 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (fire) begin
                        cs_n_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign sck  = sck_q;
    assign cs_n = cs_n_q;
    assign done = done_q;
    assign mosi = cs_n_q ? 1'b0 : sh_out;

endmodule

// File: rtl/spi_xfer_checker.sv
module spi_xfer_checker
    import spi_xfer_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [DIV_W-1:0] cfg_div,
    input logic             cfg_cpol,
    input logic             sck,
    input logic             mosi,
    input logic             cs_n,
    input logic             done,
    input xfer_state_t      st,
    input logic             cpol_q,
    input logic             cpha_q
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    // R1 / R12: the select is inactive whenever the controller is idle
    a_r1_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> cs_n);

    // R3: a disabled divider finishes at once without selecting the peripheral
    a_r3_off_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && cmd_valid && (cfg_div < DIV_W'(2)))
        |=> (cs_n && done && (st == ST_IDLE)));

    // R4: the idle clock level follows the polarity input
    a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(st) == ST_IDLE)) |-> (sck == $past(cfg_cpol)));

    // R5 / R6: data out never moves on an edge that samples data in
    a_r5_mosi_held_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && (sck != $past(sck)) && ((sck != cpol_q) != cpha_q))
        |-> $stable(mosi));

    // R4 / R12: the select releases with the clock back at its idle level
    a_r12_release_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (sck == cpol_q));

    // R11: the done pulse comes before the select is released
    a_r11_done_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !done);

endmodule

bind spi_xfer_engine spi_xfer_checker #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cfg_div   (cfg_div),
    .cfg_cpol  (cfg_cpol),
    .sck       (sck),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .done      (done),
    .st        (st),
    .cpol_q    (cpol_q),
    .cpha_q    (cpha_q)
);

// File: tb/spi_xfer_engine_test.sv
module spi_xfer_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_div = 8'd2;
    logic [6:0]  cfg_lead = 7'd1;
    logic [3:0]  cfg_len = 4'd0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_lead_sel = 1'b0;
    logic        cmd_len_sel = 1'b0;
    logic [15:0] tx_data = 16'h0;
    logic        miso = 1'b0;
    logic        sck, mosi, cs_n, done;
    logic [15:0] rx_data;

    int checks = 0;
    int errors = 0;

    spi_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_lead(cfg_lead),
        .cfg_len(cfg_len), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cmd_valid(cmd_valid), .cmd_lead_sel(cmd_lead_sel), .cmd_len_sel(cmd_len_sel),
        .tx_data(tx_data), .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .rx_data(rx_data), .done(done)
    );

    always #5 clk = ~clk;

    task automatic chk(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int frame_bits(input bit sel, input int code);
        if (!sel) return 8;
        if (code == 0) return 16;
        if (code < 8) return 8;
        return code;
    endfunction

    function automatic int lead_of(input bit sel, input int lead, input int div);
        if (!sel) return div;
        return (lead == 0) ? 1 : lead;
    endfunction

    // ---------------- behavioural reference, timeline since acceptance ----------------
    bit          m_act;
    int          m_t, m_L, m_div, m_n;
    bit          m_cpol, m_cpha;
    logic [15:0] m_tx;
    logic        exp_sck, exp_cs_n, exp_mosi, exp_done;
    logic [15:0] exp_rx;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act = 0; exp_sck = 0; exp_cs_n = 1; exp_mosi = 0; exp_done = 0; exp_rx = 0;
        end else begin
            exp_done = 0;
            if (m_act) begin
                int k, e, s;
                m_t++;
                if (m_t >= m_L && ((m_t - m_L) % m_div) == 0) begin
                    e = (m_t - m_L) / m_div + 1;
                    if (e <= 2 * m_n && ((m_cpha && e % 2 == 0) || (!m_cpha && e % 2 == 1))) begin
                        exp_rx = {exp_rx[14:0], miso};
                        if (e == (m_cpha ? 2 * m_n : 2 * m_n - 1)) exp_done = 1;
                    end
                end
                if (m_t < m_L) k = 0;
                else begin
                    k = (m_t - m_L) / m_div + 1;
                    if (k > 2 * m_n) k = 2 * m_n;
                end
                exp_sck = m_cpol ^ k[0];
                if (m_cpha) s = (k >= 3) ? (k - 1) / 2 : 0;
                else s = (k / 2 < m_n - 1) ? k / 2 : m_n - 1;
                exp_mosi = m_tx[m_n - 1 - s];
                if (m_t == m_L + 2 * m_n * m_div) begin
                    m_act = 0; exp_cs_n = 1; exp_mosi = 0;
                end
            end else begin
                exp_sck = cfg_cpol;
                if (cmd_valid) begin
                    if (cfg_div < 2) exp_done = 1;
                    else begin
                        m_act = 1; m_t = 0;
                        m_div = cfg_div; m_cpol = cfg_cpol; m_cpha = cfg_cpha;
                        m_n = frame_bits(cmd_len_sel, cfg_len);
                        m_L = lead_of(cmd_lead_sel, cfg_lead, cfg_div);
                        m_tx = tx_data;
                        exp_cs_n = 0; exp_rx = 0;
                        exp_mosi = m_tx[m_n - 1];
                    end
                end
            end
        end
    end

    // compare against the reference on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sck, exp_sck, "R2", "sck vs reference");
            chk(cs_n, exp_cs_n, "R12", "cs_n vs reference");
            chk(mosi, exp_mosi, m_cpha ? "R6" : "R5", "mosi vs reference");
            chk(done, exp_done, "R11", "done vs reference");
            chk(rx_data, exp_rx, "R10", "rx_data vs reference");
        end
    end

    // random serial input
    initial forever begin
        @(negedge clk);
        miso = 1'($urandom % 2);
    end

    task automatic xfer(input int div, input bit cpol, input bit cpha, input bit lsel,
                        input int lead, input bit nsel, input int code,
                        input logic [15:0] tx, input bit disturb);
        int L, n, c, tog, gap, dn;
        logic prev;
        @(negedge clk);
        cfg_div = 8'(div); cfg_cpol = cpol; cfg_cpha = cpha; cfg_lead = 7'(lead);
        cfg_len = 4'(code); cmd_lead_sel = lsel; cmd_len_sel = nsel; tx_data = tx;
        repeat (2) @(negedge clk);
        chk(sck, cpol, "R4", "idle sck level before frame");
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        L = lead_of(lsel, lead, div);
        n = frame_bits(nsel, code);
        chk(cs_n, 0, "R7", "cs_n low after accept");
        c = 0;
        while (sck == cpol) begin @(negedge clk); c++; end
        chk(c, L, lsel ? "R8" : "R7", "lead clocks before first edge");
        tog = 1; gap = 0; prev = sck; dn = 0;
        while (cs_n == 1'b0) begin
            @(negedge clk);
            gap++;
            if (disturb && tog == 1 && gap == 1) begin
                cmd_valid = 1'b1; cfg_div = 8'd7; cfg_len = 4'd9; cfg_cpha = ~cpha;
            end else begin
                cmd_valid = 1'b0;
            end
            if (done) dn++;
            if (cs_n) chk(gap, div, "R12", "clocks from last edge to release");
            else if (sck != prev) begin
                tog++;
                chk(gap, div, disturb ? "R13" : "R2", "clocks between sck edges");
                gap = 0; prev = sck;
            end
        end
        chk(tog, 2 * n, "R9", "sck edges in frame");
        chk(dn, 1, "R11", "done pulses in frame");
        chk(sck, cpol, "R4", "sck level after frame");
        chk(rx_data, exp_rx, "R10", "received word");
        if (disturb) begin
            repeat (4) begin
                @(negedge clk);
                chk(cs_n, 1, "R13", "no frame from command issued while busy");
            end
        end
    endtask

    task automatic off(input int div, input bit cpol);
        @(negedge clk);
        cfg_div = 8'(div); cfg_cpol = cpol;
        repeat (2) @(negedge clk);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(done, 1, "R3", "done after disabled command");
        chk(cs_n, 1, "R3", "cs_n held with disabled divider");
        repeat (3) begin
            @(negedge clk);
            chk(cs_n, 1, "R3", "cs_n stays high");
            chk(sck, cpol, "R3", "sck stays idle");
            chk(done, 0, "R3", "done is a single pulse");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sck, 0, "R1", "sck in reset");
        chk(cs_n, 1, "R1", "cs_n in reset");
        chk(mosi, 0, "R1", "mosi in reset");
        chk(done, 0, "R1", "done in reset");
        chk(rx_data, 0, "R1", "rx_data in reset");
        rst_n = 1'b1;
        @(negedge clk); cfg_cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk(sck, 1, "R4", "idle sck follows polarity 1");
        cfg_cpol = 1'b0;
        repeat (2) @(negedge clk);
        chk(sck, 0, "R4", "idle sck follows polarity 0");

        xfer(2,   0, 0, 0, 0,   0, 0,  16'h00A5, 0);
        xfer(3,   1, 1, 1, 5,   1, 12, 16'h0B3C, 0);
        xfer(4,   0, 1, 0, 99,  1, 0,  16'hC3E1, 0);
        xfer(2,   1, 0, 1, 1,   0, 12, 16'h005A, 0);
        xfer(5,   0, 0, 1, 127, 1, 5,  16'h0081, 0);
        xfer(2,   1, 1, 0, 0,   1, 15, 16'h7FFF, 0);
        xfer(6,   0, 0, 0, 0,   1, 9,  16'h0155, 1);
        off(1, 1);
        off(0, 0);
        xfer(2,   0, 1, 1, 3,   1, 16, 16'h9C3B, 0);
        xfer(255, 1, 0, 0, 0,   0, 0,  16'h003C, 0);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule